// File: doc/BRIEF.md
# Interrupt Message Requester for a PCI Express Endpoint

This block sits between application logic and the transmit side of a PCI Express endpoint. It turns two kinds of application interrupt into message requests. The legacy wire interrupt is a level-sensitive status input. The block compares that level with the level it last reported upstream. When they differ, it requests an assert message or a deassert message on a valid/accept/sent handshake. It raises a one-cycle acknowledge once the transmit side reports that the message has left.

For message-signalled interrupts, the block takes a request pulse and a 5-bit vector number. It builds the message data by placing the low vector bits into the configured base data. The number of bits placed follows the configured multiple-message field. It then holds the request until the transmit side accepts it, and returns a one-cycle acknowledge.

Packet framing, the link layer and configuration storage belong to other blocks. Configuration values arrive here as plain inputs.

Top module: `irq_msg_req`

## Requirements
- R1: After reset (rst_n low, synchronous), msg_valid, intx_ack, msi_valid and msi_ack are all low. The level last reported upstream is taken as deasserted.
- R2: When intx_level rises while cfg_intx_off is low, exactly one message request is issued with msg_code = 8'h20 (assert).
- R3: When intx_level falls after an assert has been sent, exactly one message request is issued with msg_code = 8'h24 (deassert).
- R4: intx_ack pulses high for exactly one cycle, in the cycle after msg_sent is seen for an outstanding message. It is never high before that.
- R5: Only one legacy message is outstanding at a time. If the level changes while a message is pending, that message is finished first, and then the message matching the current level is sent. Accepted codes strictly alternate, starting with 8'h20.
- R6: While msg_valid is high and msg_accept is low, msg_valid stays high and msg_code stays unchanged.
- R7: While cfg_intx_off is high, no assert message is issued. If an assert has already been sent, a deassert (8'h24) is still issued.
- R8: msi_data equals cfg_msi_base, except that its low N bits come from msi_vec. N is the value of cfg_msi_mme (0..5); the values 6 and 7 are treated as 5.
- R9: On msi_req, the merged data is latched. msi_valid and msi_data are then held until msi_accept. msi_ack pulses for one cycle in the cycle after acceptance. msi_req pulses while a request is pending leave msi_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intx_level | input | 1 | Application legacy interrupt status level |
| intx_ack | output | 1 | One-cycle acknowledge after a legacy message was sent |
| cfg_intx_off | input | 1 | Legacy interrupt disable from configuration |
| msg_valid | output | 1 | Legacy message request valid |
| msg_code | output | 8 | Message code: 8'h20 assert, 8'h24 deassert |
| msg_accept | input | 1 | Transmit side takes the message request |
| msg_sent | input | 1 | Transmit side reports that the accepted message was sent |
| msi_req | input | 1 | Application MSI request pulse |
| msi_vec | input | 5 | Application MSI vector number |
| cfg_msi_base | input | 16 | Configured MSI base message data |
| cfg_msi_mme | input | 3 | Enabled vector count as a log2 value |
| msi_valid | output | 1 | MSI request pending toward transmit |
| msi_data | output | 16 | Merged MSI message data |
| msi_accept | input | 1 | Transmit side takes the MSI request |
| msi_ack | output | 1 | One-cycle MSI acknowledge |

## Verification
Some rules can be judged on every cycle from the ports alone, and the assertions check those:
- requests stay stable until accepted, for both the legacy and the MSI path;
- the legacy codes strictly alternate, starting with assert;
- both acknowledges are single-cycle pulses that follow the transmit-side event.

Other behaviour depends on the stimulus, so only the bench scenarios can show it:
- that a level change produces a message at all;
- that a change arriving mid-message is queued behind the pending one;
- that the disable bit holds back an assert while still letting a deassert out;
- that each vector-count setting merges the correct bits.

// File: rtl/irq_msg_pkg.sv
// Shared constants and types for the interrupt message requester.
package irq_msg_pkg;
    localparam logic [7:0] CODE_ASSERT   = 8'h20;
    localparam logic [7:0] CODE_DEASSERT = 8'h24;

    typedef enum logic [1:0] {
        LG_IDLE = 2'd0,
        LG_REQ  = 2'd1,
        LG_TX   = 2'd2
    } legacy_state_t;
endpackage

// File: rtl/intx_msg_fsm.sv
// Legacy interrupt sequencer.
// Compares the wanted level (status AND NOT disable) with the level last
// reported upstream, and requests one message per difference.
// Assumes msg_sent arrives only after msg_accept for the same message.
module intx_msg_fsm
    import irq_msg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic       off_i,
    input  logic       accept_i,
    input  logic       sent_i,
    output logic       valid_o,
    output logic [7:0] code_o,
    output logic       ack_o
);
    legacy_state_t state_q;
    logic          up_q;      // level last reported upstream
    logic          pend_q;    // level carried by the pending message
    logic          want;

    // Level the upstream side should see.
    always_comb want = lvl_i & ~off_i;

    // Sequencer: issue, wait for accept, wait for sent, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LG_IDLE;
            up_q    <= 1'b0;
            pend_q  <= 1'b0;
            code_o  <= CODE_DEASSERT;
            ack_o   <= 1'b0;
        end else begin
            ack_o <= 1'b0;
            unique case (state_q)
                LG_IDLE: if (want != up_q) begin
                    pend_q  <= want;
                    code_o  <= want ? CODE_ASSERT : CODE_DEASSERT;
                    state_q <= LG_REQ;
                end
                LG_REQ: if (accept_i) state_q <= LG_TX;
                LG_TX: if (sent_i) begin
                    up_q    <= pend_q;
                    ack_o   <= 1'b1;
                    state_q <= LG_IDLE;
                end
                default: state_q <= LG_IDLE;
            endcase
        end
    end

    // Request is valid only while waiting for acceptance.
    always_comb valid_o = (state_q == LG_REQ);
endmodule

// File: rtl/msi_data_merge.sv
// MSI data former.
// Replaces the low N base bits with vector bits, where N is the log2
// vector count, clamped to the vector width.
// Purely combinational; assumes DATA_W >= VEC_W.
module msi_data_merge #(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 5,
    parameter int MME_W  = 3
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic [MME_W-1:0]  mme_i,
    output logic [DATA_W-1:0] data_o
);
    logic [VEC_W-1:0] mask;
    int               nbits;

    // Clamp the enabled bit count to the vector width.
    always_comb nbits = (int'(mme_i) > VEC_W) ? VEC_W : int'(mme_i);

    // One mask bit per vector bit position.
    for (genvar i = 0; i < VEC_W; i++) begin : g_mask
        assign mask[i] = (i < nbits);
    end

    // Merge vector bits under the mask into the base data.
    always_comb begin
        data_o             = base_i;
        data_o[VEC_W-1:0]  = (base_i[VEC_W-1:0] & ~mask) | (vec_i & mask);
    end
endmodule

// File: rtl/msi_req_ctrl.sv
// MSI request holder.
// Latches data on a request, holds it until accepted, then pulses an ack.
// New requests while one is pending are dropped.
module msi_req_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              accept_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ack_o
);
    // Hold register and acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            ack_o   <= 1'b0;
        end else begin
            ack_o <= 1'b0;
            if (valid_o) begin
                if (accept_i) begin
                    valid_o <= 1'b0;
                    ack_o   <= 1'b1;
                end
            end else if (req_i) begin
                valid_o <= 1'b1;
                data_o  <= data_i;
            end
        end
    end
endmodule

// File: rtl/irq_msg_req.sv
// Interrupt message requester (top).
// Legacy level-to-message sequencing plus MSI data forming and holding.
// All handshakes are synchronous to clk.
module irq_msg_req #(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 5,
    parameter int MME_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intx_level,
    output logic              intx_ack,
    input  logic              cfg_intx_off,
    output logic              msg_valid,
    output logic [7:0]        msg_code,
    input  logic              msg_accept,
    input  logic              msg_sent,
    input  logic              msi_req,
    input  logic [VEC_W-1:0]  msi_vec,
    input  logic [DATA_W-1:0] cfg_msi_base,
    input  logic [MME_W-1:0]  cfg_msi_mme,
    output logic              msi_valid,
    output logic [DATA_W-1:0] msi_data,
    input  logic              msi_accept,
    output logic              msi_ack
);
    logic [DATA_W-1:0] merged;

    intx_msg_fsm u_legacy (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (intx_level),
        .off_i    (cfg_intx_off),
        .accept_i (msg_accept),
        .sent_i   (msg_sent),
        .valid_o  (msg_valid),
        .code_o   (msg_code),
        .ack_o    (intx_ack)
    );

    msi_data_merge #(.DATA_W(DATA_W), .VEC_W(VEC_W), .MME_W(MME_W)) u_merge (
        .base_i (cfg_msi_base),
        .vec_i  (msi_vec),
        .mme_i  (cfg_msi_mme),
        .data_o (merged)
    );

    msi_req_ctrl #(.DATA_W(DATA_W)) u_msi (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (msi_req),
        .data_i   (merged),
        .accept_i (msi_accept),
        .valid_o  (msi_valid),
        .data_o   (msi_data),
        .ack_o    (msi_ack)
    );
endmodule

// File: rtl/irq_msg_req_chk.sv
// Port-level checker for irq_msg_req, attached by bind.
module irq_msg_req_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              intx_ack,
    input logic              msg_valid,
    input logic [7:0]        msg_code,
    input logic              msg_accept,
    input logic              msg_sent,
    input logic              msi_valid,
    input logic [DATA_W-1:0] msi_data,
    input logic              msi_accept,
    input logic              msi_ack
);
    logic       seen_q;
    logic [7:0] last_q;

    // Remember the last accepted legacy code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= 8'h00;
        end else if (msg_valid && msg_accept) begin
            seen_q <= 1'b1;
            last_q <= msg_code;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !msg_valid && !intx_ack && !msi_valid && !msi_ack); // R1
    AST_ACK_AFTER_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        intx_ack |-> $past(msg_sent)); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        intx_ack |=> !intx_ack); // R4
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_accept && seen_q |-> msg_code != last_q); // R5
    AST_FIRST_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !seen_q |-> msg_code == 8'h20); // R5
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_accept |=> msg_valid && $stable(msg_code)); // R6
    AST_MSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && !msi_accept |=> msi_valid && $stable(msi_data)); // R9
    AST_MSI_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid && msi_accept |=> msi_ack && !msi_valid); // R9
endmodule

bind irq_msg_req irq_msg_req_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .intx_ack   (intx_ack),
    .msg_valid  (msg_valid),
    .msg_code   (msg_code),
    .msg_accept (msg_accept),
    .msg_sent   (msg_sent),
    .msi_valid  (msi_valid),
    .msi_data   (msi_data),
    .msi_accept (msi_accept),
    .msi_ack    (msi_ack)
);

// File: tb/irq_msg_req_tb_top.sv
// Self-checking bench for irq_msg_req.
module irq_msg_req_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        intx_level = 1'b0, cfg_intx_off = 1'b0;
    logic        msg_accept = 1'b0, msg_sent = 1'b0;
    logic        msi_req = 1'b0, msi_accept = 1'b0;
    logic [4:0]  msi_vec = '0;
    logic [15:0] cfg_msi_base = '0;
    logic [2:0]  cfg_msi_mme = '0;
    logic        intx_ack, msg_valid, msi_valid, msi_ack;
    logic [7:0]  msg_code;
    logic [15:0] msi_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_msg_req dut_i (.*);

    // {mme[2:0], base[15:0], vec[4:0], expected[15:0]}
    localparam logic [39:0] MSI_TBL [8] = '{
        {3'd0, 16'hABCD, 5'h1F, 16'hABCD},
        {3'd1, 16'hABCD, 5'h1E, 16'hABCC},
        {3'd2, 16'h4930, 5'h03, 16'h4933},
        {3'd3, 16'h4930, 5'h1D, 16'h4935},
        {3'd4, 16'hFFF0, 5'h0A, 16'hFFFA},
        {3'd5, 16'h1200, 5'h1F, 16'h121F},
        {3'd7, 16'h12E0, 5'h05, 16'h12E5},
        {3'd6, 16'h0000, 5'h13, 16'h0013}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Wait for a legacy request, check it, and run it to completion.
    task automatic legacy_msg(input logic [7:0] exp_code, input string tag);
        for (int i = 0; i < 8 && !msg_valid; i++) step();
        chk({tag, " valid"}, msg_valid, 1);
        chk({tag, " code"}, msg_code, exp_code);
        chk("R4 no early ack", intx_ack, 0);
        msg_accept = 1'b1;
        step();
        msg_accept = 1'b0;
        chk("R4 no ack before sent", intx_ack, 0);
        msg_sent = 1'b1;
        step();
        msg_sent = 1'b0;
        chk("R4 ack after sent", intx_ack, 1);
        step();
        chk("R4 ack one cycle", intx_ack, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        step();
        step();
        // R1: reset state
        chk("R1 msg_valid", msg_valid, 0);
        chk("R1 intx_ack", intx_ack, 0);
        chk("R1 msi_valid", msi_valid, 0);
        chk("R1 msi_ack", msi_ack, 0);
        rst_n = 1'b1;
        step();
        chk("R1 no msg after reset", msg_valid, 0);

        // R8 / R9: table of MSI merges
        foreach (MSI_TBL[k]) begin
            cfg_msi_mme  = MSI_TBL[k][39:37];
            cfg_msi_base = MSI_TBL[k][36:21];
            msi_vec      = MSI_TBL[k][20:16];
            msi_req      = 1'b1;
            step();
            msi_req = 1'b0;
            chk("R9 msi_valid", msi_valid, 1);
            chk("R8 msi_data", msi_data, MSI_TBL[k][15:0]);
            msi_accept = 1'b1;
            step();
            msi_accept = 1'b0;
            chk("R9 msi_ack", msi_ack, 1);
            chk("R9 valid cleared", msi_valid, 0);
            step();
            chk("R9 ack one cycle", msi_ack, 0);
        end

        // R9: request latched; new request while pending ignored; hold until accept
        cfg_msi_mme = 3'd5; cfg_msi_base = 16'h8000; msi_vec = 5'h04;
        msi_req = 1'b1;
        step();
        msi_req = 1'b1; msi_vec = 5'h1B; cfg_msi_base = 16'h0100;
        step();
        msi_req = 1'b0;
        step();
        chk("R9 held valid", msi_valid, 1);
        chk("R9 data latched", msi_data, 16'h8004);
        chk("R9 no ack pending", msi_ack, 0);
        msi_accept = 1'b1;
        step();
        msi_accept = 1'b0;
        chk("R9 ack", msi_ack, 1);

        // R2 / R3: plain assert then deassert
        intx_level = 1'b1;
        legacy_msg(8'h20, "R2 assert");
        step();
        chk("R2 only one", msg_valid, 0);
        intx_level = 1'b0;
        legacy_msg(8'h24, "R3 deassert");
        step();
        chk("R3 only one", msg_valid, 0);

        // R6: request held while not accepted
        intx_level = 1'b1;
        step();
        step();
        step();
        chk("R6 still valid", msg_valid, 1);
        chk("R6 code stable", msg_code, 8'h20);
        legacy_msg(8'h20, "R6 assert");

        // R5: level drops while assert is pending; deassert follows it
        intx_level = 1'b0;
        legacy_msg(8'h24, "R5 deassert");
        intx_level = 1'b1;
        step();
        chk("R5 pending", msg_valid, 1);
        intx_level = 1'b0;
        legacy_msg(8'h20, "R5 finish assert");
        step();
        chk("R5 queued deassert", msg_valid, 1);
        legacy_msg(8'h24, "R5 queued deassert");
        step(); step(); step();
        chk("R5 no duplicate", msg_valid, 0);

        // R7: disable blocks asserts, still lets a deassert out
        cfg_intx_off = 1'b1;
        intx_level = 1'b1;
        step(); step(); step();
        chk("R7 no assert while off", msg_valid, 0);
        cfg_intx_off = 1'b0;
        legacy_msg(8'h20, "R7 assert when enabled");
        cfg_intx_off = 1'b1;
        legacy_msg(8'h24, "R7 deassert when disabled");
        step(); step();
        chk("R7 quiet after cleanup", msg_valid, 0);

        // R1: reset mid-request clears everything
        cfg_intx_off = 1'b0;
        intx_level = 1'b0;
        step();
        intx_level = 1'b1;
        msi_req = 1'b1;
        step();
        msi_req = 1'b0;
        rst_n = 1'b0;
        intx_level = 1'b0;
        step();
        chk("R1 reset msg_valid", msg_valid, 0);
        chk("R1 reset msi_valid", msi_valid, 0);
        rst_n = 1'b1;
        step(); step();
        chk("R1 idle after reset", msg_valid, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule